// File: doc/BRIEF.md
# Staged-Update Real-Time Clock Register Block

This block is a memory-mapped real-time clock. It holds a free-running seconds count, an alarm compare value, a control register and a small set of persistent configuration registers. A slow-clock strobe from outside drives two things. The first is a prescaler that steps the seconds count once per second. The second is a commit sequencer that models the slow, always-powered register domain.

Bus writes to control and watchdog take effect at once. Writes to seconds, alarm or persistent registers do not. Each such write lands in a bus-side shadow and raises a per-register stale flag in the status register. The sequencer then moves the shadows into the live registers one at a time, lowest flag first, and each move takes a fixed number of slow strobes. Software polls the stale flag of a register to learn when its value has landed.

When the incremented seconds value equals the alarm value and the alarm is armed, the block sets an alarm flag and a wake bit. The interrupt line follows the flag, gated by two enables. Every register offers a plain write, a bit-set alias and a bit-clear alias.

Top module: `rtc_staged_regs`

## Requirements
- R1: After reset, control, seconds, alarm, watchdog and all persistent registers read 0, no stale flag is set and `alarm_irq` is low.
- R2: `bus_addr[7:4]` selects the register. The register indices are control 0, status 1, seconds 3, alarm 4, watchdog 5, and persistent k at 6+k. `bus_addr[3:2]` selects the access: 0 replaces the value, 1 ORs in the data, 2 clears the bits that are 1 in the data, and 3 is ignored with no effect and no stale flag.
- R3: A write to a staged register sets its stale flag from the next cycle. Persistent k uses status bit 16+k, alarm uses bit 22 and seconds uses bit 23. Reads keep returning the old live value until the commit. A set or clear access to a stale register acts on its pending value.
- R4: Commits happen one at a time. At the strobe where the sequencer is idle, it picks the lowest set stale bit. So pending persistent registers land first, then alarm, then seconds. A stale flag clears in the cycle its value lands.
- R5: An idle sequencer needs COMMIT_TICKS+1 strobes to commit a register: one strobe to pick it and COMMIT_TICKS strobes to count. A new write to the register being committed restarts its count, after which COMMIT_TICKS more strobes are needed.
- R6: Seconds steps by one every SLOW_PER_SEC strobes and wraps from 0xFFFFFFFF to 0. A seconds commit in the same cycle takes precedence over the step.
- R7: Persistent0 bit 2 is alarm enable. If it is set, a step that makes seconds equal to alarm sets control bit 2 (the alarm flag) and persistent0 bit 7 (the wake bit). If it is clear, a match sets neither.
- R8: `alarm_irq` is high exactly while control bit 2, control bit 0 (interrupt enable) and persistent0 bit 2 are all set.
- R9: Only a clear access to control with data bit 2 set lowers the alarm flag. Replace and set accesses leave that bit unchanged.
- R10: Status reads bit 31 as 1. Bit 28 reads 1 when XTAL_SEL is 1 (32000 Hz) and bit 27 reads 1 when XTAL_SEL is 2 (32768 Hz). Bits 23:16 carry the stale flags and all other bits read 0. Writes to status are ignored. Control bits other than 0, 1, 2 and 4 read 0.
- R11: The watchdog register is not staged: any write access updates it in the same cycle, with the same access semantics as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_stb | input | 1 | One-cycle strobe per slow-clock period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Word address (byte address bits 7:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with COMMIT_TICKS=3, SLOW_PER_SEC=16, NUM_PERS=2 and XTAL_SEL=1. A full second then passes in sixteen hand-issued strobes, so alarm matches and the seconds wrap can be reached in a few hundred cycles. Because the strobes are hand-issued, the exact strobe count of each commit can be measured, including the restart case. The short commit time also lets four queued registers drain one after another while the bench watches the order in which their stale flags fall. The crystal selection of 1 exercises the status bit that the default value leaves at zero.

// File: rtl/rtc_pkg.sv
// Shared constants, access type and access helper for the staged RTC block.
package rtc_pkg;
    localparam int REG_W   = 32;
    localparam int NSLOTS  = 8;
    localparam int SLOT_W  = 3;
    localparam logic [SLOT_W-1:0] SLOT_ALARM = 3'd6;
    localparam logic [SLOT_W-1:0] SLOT_SEC   = 3'd7;

    localparam logic [3:0] RG_CTRL  = 4'd0;
    localparam logic [3:0] RG_STAT  = 4'd1;
    localparam logic [3:0] RG_SEC   = 4'd3;
    localparam logic [3:0] RG_ALARM = 4'd4;
    localparam logic [3:0] RG_WDOG  = 4'd5;
    localparam logic [3:0] RG_PERS0 = 4'd6;

    localparam logic [4:0] CTRL_RW   = 5'b10011;
    localparam logic [4:0] CTRL_FLAG = 5'b00100;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    // Applies one bus access kind to an old register value.
    function automatic logic [REG_W-1:0] apply_acc(acc_e a, logic [REG_W-1:0] old,
                                                   logic [REG_W-1:0] d);
        case (a)
            ACC_WRITE: return d;
            ACC_SET:   return old | d;
            ACC_CLR:   return old & ~d;
            default:   return old;
        endcase
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the slow-clock strobe down to a one-second tick.
// Assumes slow_stb is a single-cycle pulse; tick is high in the cycle of
// the DIV-th strobe of each period.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_stb,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = slow_stb && (cnt_q == LAST);

    // Count strobes modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (slow_stb)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_commit_seq.sv
// Stale-flag tracker and serial commit sequencer.
// A write strobe marks a slot stale. On a strobe while idle, the lowest
// stale slot is picked. After HOLD further strobes its commit fires for one
// cycle and the flag clears. A rewrite of the busy slot restarts its count.
module rtc_commit_seq
    import rtc_pkg::*;
#(
    parameter int HOLD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_stb,
    input  logic [NSLOTS-1:0] wr_stage,
    output logic [NSLOTS-1:0] stale_q,
    output logic              commit_vld,
    output logic [SLOT_W-1:0] commit_idx
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic              busy_q;
    logic [SLOT_W-1:0] idx_q;
    logic [CW-1:0]     cnt_q;
    logic [SLOT_W-1:0] pick;
    logic              rewrite;
    logic [NSLOTS-1:0] done_mask;

    // Priority pick: lowest-index stale slot wins.
    always_comb begin
        pick = '0;
        for (int i = NSLOTS - 1; i >= 0; i--)
            if (stale_q[i]) pick = SLOT_W'(i);
    end

    assign rewrite    = busy_q && wr_stage[idx_q];
    assign commit_vld = busy_q && slow_stb && !rewrite && (cnt_q == LAST);
    assign commit_idx = idx_q;
    assign done_mask  = commit_vld ? (NSLOTS'(1) << idx_q) : '0;

    // Sequencer state: select, count strobes, restart, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (slow_stb && (stale_q != '0)) begin
                busy_q <= 1'b1;
                idx_q  <= pick;
                cnt_q  <= '0;
            end
        end else if (rewrite) begin
            cnt_q <= '0;
        end else if (commit_vld) begin
            busy_q <= 1'b0;
        end else if (slow_stb) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Stale flags: set by writes, cleared by the commit of their slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stale_q <= '0;
        else
            stale_q <= (stale_q & ~done_mask) | wr_stage;
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Seconds incrementer and alarm comparator, combinational.
// Assumes the caller drops 'armed' in a cycle where seconds is being
// overwritten by a commit.
module rtc_alarm_cmp #(
    parameter int TW = 32
) (
    input  logic [TW-1:0] sec_q,
    input  logic [TW-1:0] alarm_q,
    input  logic          tick,
    input  logic          armed,
    output logic [TW-1:0] sec_inc,
    output logic          hit
);
    assign sec_inc = sec_q + 1'b1;
    assign hit     = tick && armed && (sec_inc == alarm_q);
endmodule

// File: rtl/rtc_staged_regs.sv
// Top of the staged-update RTC: decode, shadows, live registers, read mux.
// Assumes NUM_PERS is between 1 and 6 and slow_stb is a one-cycle pulse.
module rtc_staged_regs
    import rtc_pkg::*;
#(
    parameter int NUM_PERS     = 2,
    parameter int COMMIT_TICKS = 8,
    parameter int SLOW_PER_SEC = 32768,
    parameter int XTAL_SEL     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_stb,
    input  logic             bus_wr,
    input  logic [7:2]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             alarm_irq
);
    logic [3:0]        rg;
    acc_e              acc;
    logic              wr_live;
    logic [NSLOTS-1:0] wr_stage;
    logic [NSLOTS-1:0] stale_q;
    logic              commit_vld;
    logic [SLOT_W-1:0] commit_idx;
    logic              sec_tick;
    logic              sec_commit;
    logic              alarm_hit;
    logic [REG_W-1:0]  sec_inc;
    logic [REG_W-1:0]  sec_q;
    logic [REG_W-1:0]  alarm_q;
    logic [REG_W-1:0]  wdog_q;
    logic [4:0]        ctrl_q;
    logic [4:0]        ctrl_d;
    logic              ctrl_flag_clr;
    logic [REG_W-1:0]  stat_w;
    logic [NSLOTS-1:0][REG_W-1:0]   shadow_v;
    logic [NSLOTS-1:0][REG_W-1:0]   comm_v;
    logic [NUM_PERS-1:0][REG_W-1:0] pers_v;

    assign rg      = bus_addr[7:4];
    assign acc     = acc_e'(bus_addr[3:2]);
    assign wr_live = bus_wr && (acc != ACC_NONE);

    rtc_prescaler #(.DIV(SLOW_PER_SEC)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_stb (slow_stb),
        .tick     (sec_tick)
    );

    rtc_commit_seq #(.HOLD(COMMIT_TICKS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_stb   (slow_stb),
        .wr_stage   (wr_stage),
        .stale_q    (stale_q),
        .commit_vld (commit_vld),
        .commit_idx (commit_idx)
    );

    assign sec_commit = commit_vld && (commit_idx == SLOT_SEC);

    rtc_alarm_cmp #(.TW(REG_W)) u_cmp (
        .sec_q   (sec_q),
        .alarm_q (alarm_q),
        .tick    (sec_tick),
        .armed   (pers_v[0][2] && !sec_commit),
        .sec_inc (sec_inc),
        .hit     (alarm_hit)
    );

    // One staging slot per register that commits through the sequencer.
    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        localparam bit LIVE = (g < NUM_PERS) || (g == int'(SLOT_ALARM)) ||
                              (g == int'(SLOT_SEC));
        localparam logic [3:0] RGN = (g == int'(SLOT_SEC))   ? RG_SEC :
                                     (g == int'(SLOT_ALARM)) ? RG_ALARM :
                                     4'(int'(RG_PERS0) + g);
        if (LIVE) begin : g_live
            logic [REG_W-1:0] sh_q;
            assign wr_stage[g] = wr_live && (rg == RGN);
            assign shadow_v[g] = sh_q;
            // Capture the pending value; aliases act on the pending value if stale.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sh_q <= '0;
                else if (wr_stage[g])
                    sh_q <= apply_acc(acc, stale_q[g] ? sh_q : comm_v[g], bus_wdata);
            end
        end else begin : g_dead
            assign wr_stage[g] = 1'b0;
            assign shadow_v[g] = '0;
        end
    end

    // Live persistent registers; persistent0 also carries the wake bit.
    for (genvar k = 0; k < NUM_PERS; k++) begin : g_pers
        logic [REG_W-1:0] pv_q;
        assign pers_v[k] = pv_q;
        // Load on commit of this slot, else record a wake event on slot 0.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pv_q <= '0;
            else if (commit_vld && (commit_idx == SLOT_W'(k)))
                pv_q <= shadow_v[k];
            else if ((k == 0) && alarm_hit)
                pv_q[7] <= 1'b1;
        end
    end

    // Map every slot to its live value for alias evaluation.
    always_comb begin
        for (int s = 0; s < NSLOTS; s++)
            comm_v[s] = '0;
        for (int k = 0; k < NUM_PERS; k++)
            comm_v[k] = pers_v[k];
        comm_v[SLOT_ALARM] = alarm_q;
        comm_v[SLOT_SEC]   = sec_q;
    end

    // Seconds counter: commit overrides the per-second step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_q <= '0;
        else if (sec_commit)
            sec_q <= shadow_v[SLOT_SEC];
        else if (sec_tick)
            sec_q <= sec_inc;
    end

    // Alarm compare register, loaded only by its commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= '0;
        else if (commit_vld && (commit_idx == SLOT_ALARM))
            alarm_q <= shadow_v[SLOT_ALARM];
    end

    // Watchdog register: immediate, not staged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdog_q <= '0;
        else if (wr_live && (rg == RG_WDOG))
            wdog_q <= apply_acc(acc, wdog_q, bus_wdata);
    end

    assign ctrl_flag_clr = wr_live && (rg == RG_CTRL) && (acc == ACC_CLR) && bus_wdata[2];

    // Next control value: bus may only clear the flag; a match sets it.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_live && (rg == RG_CTRL)) begin
            case (acc)
                ACC_WRITE: ctrl_d = (ctrl_q & ~CTRL_RW) | (bus_wdata[4:0] & CTRL_RW);
                ACC_SET:   ctrl_d = ctrl_q | (bus_wdata[4:0] & CTRL_RW);
                ACC_CLR:   ctrl_d = ctrl_q & ~(bus_wdata[4:0] & (CTRL_RW | CTRL_FLAG));
                default:   ctrl_d = ctrl_q;
            endcase
        end
        if (alarm_hit)
            ctrl_d[2] = 1'b1;
    end

    // Control register state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_d;
    end

    assign stat_w = {1'b1, 2'b00, (XTAL_SEL == 1), (XTAL_SEL == 2), 3'b000,
                     stale_q, 16'h0000};

    // Read mux, combinational on the word address.
    always_comb begin
        bus_rdata = '0;
        case (rg)
            RG_CTRL:  bus_rdata = {27'd0, ctrl_q};
            RG_STAT:  bus_rdata = stat_w;
            RG_SEC:   bus_rdata = sec_q;
            RG_ALARM: bus_rdata = alarm_q;
            RG_WDOG:  bus_rdata = wdog_q;
            default: begin
                for (int k = 0; k < NUM_PERS; k++)
                    if (rg == 4'(int'(RG_PERS0) + k)) bus_rdata = pers_v[k];
            end
        endcase
    end

    assign alarm_irq = ctrl_q[2] && ctrl_q[0] && pers_v[0][2];
endmodule

// File: rtl/rtc_staged_regs_chk.sv
// Property checker for rtc_staged_regs, attached by bind below.
// Assumes synchronous active-low reset held for at least one edge.
module rtc_staged_regs_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NSLOTS-1:0] wr_stage,
    input logic [NSLOTS-1:0] stale_q,
    input logic              commit_vld,
    input logic [SLOT_W-1:0] commit_idx,
    input logic              sec_tick,
    input logic [REG_W-1:0]  sec_q,
    input logic              alarm_flag,
    input logic              flag_clr
);
    // R3: a staging write leaves its stale flag set on the next cycle.
    p_stale_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stage != '0) |=> ((stale_q & $past(wr_stage)) == $past(wr_stage)));

    // R4: a commit only fires for a slot that is pending.
    p_commit_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> stale_q[commit_idx]);

    // R4: the committed slot's flag is clear afterwards.
    p_commit_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |=> !stale_q[$past(commit_idx)]);

    // R6: a tick without a seconds commit steps the count by one.
    p_sec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !(commit_vld && commit_idx == SLOT_SEC))
        |=> (sec_q == $past(sec_q) + 32'd1));

    // R6: with neither tick nor commit, seconds holds.
    p_sec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !(commit_vld && commit_idx == SLOT_SEC)) |=> $stable(sec_q));

    // R7: the alarm flag rises only as the result of a seconds tick.
    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick));

    // R9: the alarm flag falls only after a clear-alias write of its bit.
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(flag_clr));
endmodule

bind rtc_staged_regs rtc_staged_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stage   (wr_stage),
    .stale_q    (stale_q),
    .commit_vld (commit_vld),
    .commit_idx (commit_idx),
    .sec_tick   (sec_tick),
    .sec_q      (sec_q),
    .alarm_flag (ctrl_q[2]),
    .flag_clr   (ctrl_flag_clr)
);

// File: tb/rtc_staged_regs_tb.sv
// Self-checking bench for rtc_staged_regs: directed corners plus seeded random.
module rtc_staged_regs_tb;
    localparam int C   = 3;
    localparam int SPS = 16;
    localparam int NP  = 2;
    localparam int XS  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_stb = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    rtc_staged_regs #(.NUM_PERS(NP), .COMMIT_TICKS(C), .SLOW_PER_SEC(SPS),
                      .XTAL_SEL(XS)) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_stb(slow_stb), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] f_acc(int al, logic [31:0] old, logic [31:0] d);
        case (al)
            0: return d;
            1: return old | d;
            2: return old & ~d;
            default: return old;
        endcase
    endfunction

    function automatic logic [31:0] f_stat(logic [7:0] st);
        return 32'h8000_0000 | ((XS == 1) ? 32'h1000_0000 : (XS == 2) ? 32'h0800_0000 : 32'h0)
               | {8'h00, st, 16'h0000};
    endfunction

    function automatic logic [31:0] f_ctrl(int al, logic [31:0] old, logic [31:0] d);
        case (al)
            0: return (old & 32'h4) | (d & 32'h13);
            1: return old | (d & 32'h13);
            2: return old & ~(d & 32'h17);
            default: return old;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a[7:2]; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a[7:2];
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse();
        slow_stb = 1'b1;
        @(negedge clk);
        slow_stb = 1'b0;
    endtask

    // Pulse strobes until the masked stale flags are clear; return the count.
    task automatic drain(input logic [7:0] mask, output int n);
        logic [31:0] s;
        n = 0;
        rd(8'h10, s);
        while (((s[23:16] & mask) != 8'h00) && n < 80) begin
            pulse(); n++; rd(8'h10, s);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, s, wd_m, ctrl_m, p1_m, y, z, sec_a, alm;
        int n, nfall;
        int order [4];
        logic [7:0] prev;
        bit early;

        void'($urandom(32'h1234_5678));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h10, v); chk("R1 stat", v, f_stat(8'h00));
        rd(8'h30, v); chk("R1 seconds", v, 32'h0);
        rd(8'h40, v); chk("R1 alarm", v, 32'h0);
        rd(8'h50, v); chk("R1 watchdog", v, 32'h0);
        rd(8'h60, v); chk("R1 pers0", v, 32'h0);
        rd(8'h70, v); chk("R1 pers1", v, 32'h0);
        chk("R1 irq", {31'd0, alarm_irq}, 32'h0);

        // R10: status is read-only, ctrl unused bits read 0
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R10 stat write ignored", v, f_stat(8'h00));
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R10 ctrl unused bits", v, 32'h13);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R10 ctrl clear", v, 32'h0);

        // R11/R2/R9: random direct accesses to watchdog and control
        wd_m = 32'h0; ctrl_m = 32'h0;
        for (int i = 0; i < 40; i++) begin
            int al;
            logic [31:0] d;
            al = int'($urandom_range(0, 3));
            d  = $urandom;
            if ($urandom_range(0, 1) == 0) begin
                wr(8'h50 + 8'(al * 4), d);
                wd_m = f_acc(al, wd_m, d);
                rd(8'h50, v); chk("R11 watchdog access", v, wd_m);
            end else begin
                wr(8'h00 + 8'(al * 4), d);
                ctrl_m = f_ctrl(al, ctrl_m, d);
                rd(8'h00, v); chk("R9 ctrl access, flag not bus-settable", v, ctrl_m);
            end
        end
        wr(8'h08, 32'h17);

        // R3/R5: staged write to persistent1, idle commit length
        wr(8'h70, 32'hA5A5_0001);
        rd(8'h70, v); chk("R3 pers1 old until commit", v, 32'h0);
        rd(8'h10, v); chk("R3 stale bit17", v, f_stat(8'h02));
        drain(8'h02, n);
        chk("R5 idle commit strobes", 32'(n), 32'(C + 1));
        rd(8'h70, v); chk("R4 pers1 committed", v, 32'hA5A5_0001);

        // R5: rewrite of the busy slot restarts; set alias acts on pending value
        y = 32'h0F00_00F0; z = 32'h0000_0F0F;
        wr(8'h70, y);
        pulse(); pulse();
        wr(8'h74, z);
        drain(8'h02, n);
        chk("R5 restart strobes", 32'(n), 32'(C));
        rd(8'h70, v); chk("R3 alias on pending value", v, y | z);

        // R2/R3: random staged accesses to persistent1
        p1_m = y | z;
        for (int i = 0; i < 10; i++) begin
            int al;
            logic [31:0] d;
            al = int'($urandom_range(0, 2));
            d  = $urandom;
            wr(8'h70 + 8'(al * 4), d);
            p1_m = f_acc(al, p1_m, d);
            drain(8'h02, n);
            rd(8'h70, v); chk("R2 staged alias", v, p1_m);
        end

        // R2: the fourth alias is ignored
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R2 ignored alias no stale", v, f_stat(8'h00));
        rd(8'h70, v); chk("R2 ignored alias no change", v, p1_m);

        // R4: commit order with four pending registers
        wr(8'h30, 32'h0000_0100);
        wr(8'h40, 32'h0000_0050);
        wr(8'h70, 32'h0000_1234);
        wr(8'h60, 32'h0000_0001);
        rd(8'h10, v); chk("R3 four stale flags", v, f_stat(8'hC3));
        nfall = 0; n = 0;
        prev = 8'hC3;
        while (prev != 8'h00 && n < 80) begin
            logic [7:0] fell;
            pulse(); n++;
            rd(8'h10, s);
            fell = prev & ~s[23:16];
            if (fell != 8'h00) begin
                if ($countones(fell) != 1) chk("R4 one commit at a time", 32'(fell), 32'h0);
                for (int b = 0; b < 8; b++)
                    if (fell[b] && nfall < 4) begin order[nfall] = b; nfall++; end
                if (fell[7]) begin
                    rd(8'h30, sec_a); chk("R6 seconds commit wins", sec_a, 32'h100);
                end
            end
            prev = s[23:16];
        end
        chk("R4 commit count", 32'(nfall), 32'd4);
        chk("R4 order", {8'(order[0]), 8'(order[1]), 8'(order[2]), 8'(order[3])},
            32'h0001_0607);
        chk("R5 total strobes", 32'(n), 32'(4 * (C + 1)));

        // R7/R8: armed alarm match
        wr(8'h44 - 8'h04, 32'h0000_0102);
        wr(8'h64, 32'h4);
        wr(8'h04, 32'h1);
        drain(8'hFF, n);
        early = 1'b0;
        n = 0;
        rd(8'h30, s);
        while (s != 32'h102 && n < 60) begin
            if (alarm_irq) early = 1'b1;
            pulse(); n++; rd(8'h30, s);
        end
        chk("R8 no irq before match", {31'd0, early}, 32'h0);
        chk("R7 irq at match", {31'd0, alarm_irq}, 32'h1);
        rd(8'h00, v); chk("R7 flag set", v, 32'h5);
        rd(8'h60, v); chk("R7 wake bit", v, 32'h85);
        wr(8'h08, 32'h1);
        chk("R8 irq gated by enable", {31'd0, alarm_irq}, 32'h0);
        rd(8'h00, v); chk("R8 flag kept", v, 32'h4);
        wr(8'h04, 32'h1);
        chk("R8 irq re-enabled", {31'd0, alarm_irq}, 32'h1);
        wr(8'h00, 32'h1);
        rd(8'h00, v); chk("R9 replace keeps flag", v, 32'h5);
        wr(8'h08, 32'h4);
        rd(8'h00, v); chk("R9 clear alias drops flag", v, 32'h1);
        chk("R9 irq low after clear", {31'd0, alarm_irq}, 32'h0);

        // R7: disarmed match sets nothing
        wr(8'h68, 32'h4);
        drain(8'hFF, n);
        rd(8'h30, s);
        alm = s + 32'd2;
        wr(8'h40, alm);
        drain(8'hFF, n);
        for (int i = 0; i < 3 * SPS; i++) pulse();
        rd(8'h00, v); chk("R7 disarmed no flag", v, 32'h1);
        chk("R8 disarmed irq low", {31'd0, alarm_irq}, 32'h0);

        // R6: wrap from all ones to zero
        wr(8'h30, 32'hFFFF_FFFF);
        drain(8'h80, n);
        rd(8'h30, s); chk("R6 seconds loaded", s, 32'hFFFF_FFFF);
        n = 0;
        while (s == 32'hFFFF_FFFF && n < 40) begin pulse(); n++; rd(8'h30, s); end
        chk("R6 wrap to zero", s, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule